// File: doc/BRIEF.md
# Keypad Controller Command Decoder

This block turns a byte stream arriving over a two-wire serial target port into register accesses for a keypad controller. The bit-level bus logic lives elsewhere. It hands this block a strobe at each start of a write or read transaction, each received data byte, and each request for a byte to send back. The first byte of a write transaction names a command, and the bytes after it are that command's parameters. Read transactions return bytes for the most recently named command.

The block keeps the controller's settings: configuration, active time, debounce time, keypad size, clock setting, and three 16-bit GPIO words (direction, pull, level). These are presented as outputs to the neighbouring logic. Each command checks its parameters. A faulty parameter or an unknown code sets sticky error bits and raises an interrupt-status bit. The block drives an active-low interrupt line while any status bit is set. A configuration write also sends a one-cycle clear to the key-event FIFO.

A transaction state machine has four states. ST_IDLE is entered at reset. ST_CMD waits for the command byte. ST_PARAM passes later bytes through as parameters. ST_READ serves read requests. The transitions are:
- A write-start strobe moves any state to ST_CMD.
- A read-start strobe moves any state to ST_READ.
- A data byte in ST_CMD moves to ST_PARAM.
- All other states hold.

Top module: `kbd_cmd_ctrl`

## Requirements
- R1: Every start strobe sets the byte index to 0. In a write transaction the first byte becomes the command, and later bytes are parameters with index 0, 1, 2 and so on. A data byte outside a write transaction is ignored. A read request outside a read transaction produces no rd_valid. A start strobe takes precedence over a data byte or read request in the same cycle.
- R2: After rst_n the registers read: configuration 0x80, status 0x10, active time 125, debounce 3, keypad size 0x33, clock 0x08, error 0x00. The current command is 0xFF.
- R3: irq_n is low exactly while the status byte is nonzero.
- R4: The error byte uses bit0 for bad parameter, bit1 for unknown command, bit2 for key overflow and bit6 for FIFO overflow. Setting any error bit also sets status bit3. Error bits stay set until rst_n, and reading the error byte (command 0x8C) leaves it unchanged.
- R5: Command 0x83 with parameter 0xAA restores configuration, status, active time, debounce, keypad size and clock to their reset values. The error byte and the GPIO words are kept. Any other parameter sets bad parameter.
- R6: Reading status (command 0x82) returns the status byte in the first read byte and 0 in later ones. Each such read clears status, unless status bit4 (not initialised) is set.
- R7: Keypad size (command 0x90) always stores its parameter. It sets bad parameter when the low nibble is outside 3..12 or the high nibble is outside 3..8. Debounce (command 0x8F) always stores its parameter and sets bad parameter when it is 0.
- R8: A clock write (command 0x93) stores its parameter and sets bad parameter when the low two bits are 01 or 10. A clock read (0x94) returns the stored value with bits[1:0] forced to 10. A configuration read (0x92) returns only bits[3:0]. Keypad-size read is 0x91.
- R9: GPIO pull (0x84), direction (0x85) and level (0x86) writes take the low byte at parameter index 0, clearing the high byte, and the high byte at index 1. Direction reads back with 0x87 and level with 0x88: low byte, then high byte, then 0.
- R10: When a command has taken its last parameter, the current command becomes 0xFF. A further written byte sets bad parameter. A write or read of any code not listed in these requirements sets unknown command, and such a read returns 0.
- R11: The identity read (0x80) returns 0x00, then 0x04, then 0.
- R12: A configuration write (0x81, one parameter) stores the byte, clears status and pulses fifo_clr high for exactly one cycle.
- R13: Active time (0x8B, one parameter) stores the byte and presents it on act_time_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_wr | input | 1 | Start of a write transaction (one-cycle strobe) |
| start_rd | input | 1 | Start of a read transaction (one-cycle strobe) |
| wr_valid | input | 1 | A written data byte is present |
| wr_data | input | 8 | Written data byte |
| rd_req | input | 1 | Request for the next read byte |
| rd_data | output | 8 | Read byte, valid the cycle after rd_req |
| rd_valid | output | 1 | rd_data carries a fresh byte |
| irq_n | output | 1 | Interrupt, low while status is nonzero |
| fifo_clr | output | 1 | One-cycle clear to the key-event FIFO |
| cfg_o | output | 8 | Configuration register |
| act_time_o | output | 8 | Active-time register |
| debounce_o | output | 8 | Debounce register |
| key_size_o | output | 8 | Keypad size (high nibble columns, low nibble rows) |
| clock_o | output | 8 | Clock setting register |
| gpio_dir_o | output | 16 | GPIO direction word |
| gpio_pull_o | output | 16 | GPIO pull word |
| gpio_level_o | output | 16 | GPIO level word |

## Verification
Some properties are checked on every cycle:
- The index restarts at each start strobe.
- The command falls to the completed marker when its last parameter lands.
- Error bits never drop, and any new error bit comes with status bit3.
- The not-initialised bit survives a status read.
- The FIFO clear lasts one cycle, and a configuration write releases the interrupt.

The exact bytes returned by each read command, the nibble and bit-pair limits that divide good from bad parameters, and the selective soft reset can only be shown by the bench's scenarios, which compare read-back values and output registers against expected values.

// File: rtl/kbd_cmd_pkg.sv
package kbd_cmd_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_CMD   = 2'd1,
        ST_PARAM = 2'd2,
        ST_READ  = 2'd3
    } txn_state_e;

    localparam int BYTE_W = 8;
    localparam int WORD_W = 16;

    // command codes
    localparam logic [7:0] OP_ID_RD    = 8'h80;
    localparam logic [7:0] OP_CFG_WR   = 8'h81;
    localparam logic [7:0] OP_STAT_RD  = 8'h82;
    localparam logic [7:0] OP_SOFT_RST = 8'h83;
    localparam logic [7:0] OP_PULL_WR  = 8'h84;
    localparam logic [7:0] OP_DIR_WR   = 8'h85;
    localparam logic [7:0] OP_LVL_WR   = 8'h86;
    localparam logic [7:0] OP_DIR_RD   = 8'h87;
    localparam logic [7:0] OP_LVL_RD   = 8'h88;
    localparam logic [7:0] OP_ACT_WR   = 8'h8B;
    localparam logic [7:0] OP_ERR_RD   = 8'h8C;
    localparam logic [7:0] OP_DEB_WR   = 8'h8F;
    localparam logic [7:0] OP_SIZE_WR  = 8'h90;
    localparam logic [7:0] OP_SIZE_RD  = 8'h91;
    localparam logic [7:0] OP_CFG_RD   = 8'h92;
    localparam logic [7:0] OP_CLK_WR   = 8'h93;
    localparam logic [7:0] OP_CLK_RD   = 8'h94;
    localparam logic [7:0] OP_DONE     = 8'hFF;

    // error byte bit positions
    localparam int ERR_BAD_PARAM = 0;
    localparam int ERR_UNKNOWN   = 1;
    localparam int ERR_KEY_OVF   = 2;
    localparam int ERR_FIFO_OVF  = 6;

    // status byte bit positions
    localparam int STAT_ERROR  = 3;
    localparam int STAT_NOINIT = 4;

    // reset values
    localparam logic [7:0] RST_CFG    = 8'h80;
    localparam logic [7:0] RST_STAT   = 8'h10;
    localparam logic [7:0] RST_ACT    = 8'd125;
    localparam logic [7:0] RST_DEB    = 8'd3;
    localparam logic [7:0] RST_SIZE   = 8'h33;
    localparam logic [7:0] RST_CLK    = 8'h08;

    localparam logic [7:0]  SOFT_RST_KEY = 8'hAA;
    localparam logic [15:0] CHIP_ID      = 16'h0400;

    // keypad size limits (per nibble)
    localparam int KP_MIN      = 3;
    localparam int KP_ROWS_MAX = 12;
    localparam int KP_COLS_MAX = 8;

endpackage

// File: rtl/kbd_txn_fsm.sv
module kbd_txn_fsm
    import kbd_cmd_pkg::*;
#(
    parameter int IDX_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_wr,
    input  logic              start_rd,
    input  logic              wr_valid,
    input  logic [7:0]        wr_data,
    input  logic              rd_req,
    input  logic              cmd_done,
    output logic [7:0]        cmd_q,
    output logic [IDX_W-1:0]  idx_q,
    output logic              param_fire,
    output logic              rd_fire
);

    localparam logic [IDX_W-1:0] IDX_MAX = {IDX_W{1'b1}};

    txn_state_e state_q, state_d;
    logic       any_start;
    logic       cmd_load;

    assign any_start = start_wr | start_rd;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        if (start_wr) begin
            state_d = ST_CMD;
        end else if (start_rd) begin
            state_d = ST_READ;
        end else begin
            unique case (state_q)
                ST_IDLE:  begin end
                ST_CMD:   if (wr_valid) state_d = ST_PARAM;
                ST_PARAM: begin end
                ST_READ:  begin end
            endcase
        end
    end

    // outputs of the state machine
    always_comb begin
        cmd_load   = (state_q == ST_CMD)   && wr_valid && !any_start;
        param_fire = (state_q == ST_PARAM) && wr_valid && !any_start;
        rd_fire    = (state_q == ST_READ)  && rd_req   && !any_start;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx_q <= '0;
            cmd_q <= OP_DONE;
        end else begin
            if (any_start)
                idx_q <= '0;
            else if ((param_fire || rd_fire) && idx_q != IDX_MAX)
                idx_q <= idx_q + 1'b1;

            if (cmd_load)
                cmd_q <= wr_data;
            else if (param_fire && cmd_done)
                cmd_q <= OP_DONE;
        end
    end

    assert_idx_restart_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (start_wr || start_rd) |=> (idx_q == '0));

    assert_done_marker_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (param_fire && cmd_done) |=> (cmd_q == OP_DONE));

endmodule

// File: rtl/kbd_reg_file.sv
module kbd_reg_file
    import kbd_cmd_pkg::*;
#(
    parameter int IDX_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              param_fire,
    input  logic [7:0]        cmd,
    input  logic [IDX_W-1:0]  idx,
    input  logic [7:0]        wdata,
    input  logic              rd_fire,
    input  logic              rd_known,
    output logic              cmd_done,
    output logic [7:0]        cfg_q,
    output logic [7:0]        act_q,
    output logic [7:0]        deb_q,
    output logic [7:0]        size_q,
    output logic [7:0]        clk_q,
    output logic [WORD_W-1:0] dir_q,
    output logic [WORD_W-1:0] pull_q,
    output logic [WORD_W-1:0] lvl_q,
    output logic [7:0]        stat_q,
    output logic [7:0]        err_q,
    output logic              fifo_clr,
    output logic              irq_n
);

    logic [7:0]        cfg_d, act_d, deb_d, size_d, clk_d, stat_d, err_set;
    logic [WORD_W-1:0] dir_d, pull_d, lvl_d;
    logic              soft_rst, cfg_we;
    logic [3:0]        rows, cols;
    logic              first_byte;

    assign rows       = wdata[3:0];
    assign cols       = wdata[7:4];
    assign first_byte = (idx == '0);

    function automatic logic [WORD_W-1:0] word_update(
        input logic [WORD_W-1:0] cur, input logic lo, input logic [7:0] b);
        logic [WORD_W-1:0] r;
        if (lo) r = {{(WORD_W-8){1'b0}}, b};
        else    r = {b, cur[7:0]};
        return r;
    endfunction

    // write decode
    always_comb begin
        cfg_d    = cfg_q;
        act_d    = act_q;
        deb_d    = deb_q;
        size_d   = size_q;
        clk_d    = clk_q;
        dir_d    = dir_q;
        pull_d   = pull_q;
        lvl_d    = lvl_q;
        err_set  = '0;
        soft_rst = 1'b0;
        cfg_we   = 1'b0;
        cmd_done = 1'b0;
        if (param_fire) begin
            case (cmd)
                OP_CFG_WR: begin
                    cfg_d    = wdata;
                    cfg_we   = 1'b1;
                    cmd_done = 1'b1;
                end
                OP_SOFT_RST: begin
                    cmd_done = 1'b1;
                    if (wdata == SOFT_RST_KEY) soft_rst = 1'b1;
                    else err_set[ERR_BAD_PARAM] = 1'b1;
                end
                OP_PULL_WR: begin
                    pull_d   = word_update(pull_q, first_byte, wdata);
                    cmd_done = !first_byte;
                end
                OP_DIR_WR: begin
                    dir_d    = word_update(dir_q, first_byte, wdata);
                    cmd_done = !first_byte;
                end
                OP_LVL_WR: begin
                    lvl_d    = word_update(lvl_q, first_byte, wdata);
                    cmd_done = !first_byte;
                end
                OP_ACT_WR: begin
                    act_d    = wdata;
                    cmd_done = 1'b1;
                end
                OP_DEB_WR: begin
                    deb_d    = wdata;
                    cmd_done = 1'b1;
                    if (wdata == 8'd0) err_set[ERR_BAD_PARAM] = 1'b1;
                end
                OP_SIZE_WR: begin
                    size_d   = wdata;
                    cmd_done = 1'b1;
                    if (rows < 4'(KP_MIN) || rows > 4'(KP_ROWS_MAX) ||
                        cols < 4'(KP_MIN) || cols > 4'(KP_COLS_MAX))
                        err_set[ERR_BAD_PARAM] = 1'b1;
                end
                OP_CLK_WR: begin
                    clk_d    = wdata;
                    cmd_done = 1'b1;
                    if (wdata[1] ^ wdata[0]) err_set[ERR_BAD_PARAM] = 1'b1;
                end
                OP_DONE: err_set[ERR_BAD_PARAM] = 1'b1;
                default: err_set[ERR_UNKNOWN] = 1'b1;
            endcase
        end
        if (rd_fire && !rd_known) err_set[ERR_UNKNOWN] = 1'b1;
        if (soft_rst) begin
            cfg_d  = RST_CFG;
            act_d  = RST_ACT;
            deb_d  = RST_DEB;
            size_d = RST_SIZE;
            clk_d  = RST_CLK;
        end
    end

    // status next value
    always_comb begin
        stat_d = stat_q;
        if (soft_rst) stat_d = RST_STAT;
        if (cfg_we)   stat_d = '0;
        if (rd_fire && cmd == OP_STAT_RD && !stat_q[STAT_NOINIT]) stat_d = '0;
        if (|err_set) stat_d[STAT_ERROR] = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q    <= RST_CFG;
            act_q    <= RST_ACT;
            deb_q    <= RST_DEB;
            size_q   <= RST_SIZE;
            clk_q    <= RST_CLK;
            dir_q    <= '0;
            pull_q   <= '0;
            lvl_q    <= '0;
            stat_q   <= RST_STAT;
            err_q    <= '0;
            fifo_clr <= 1'b0;
        end else begin
            cfg_q    <= cfg_d;
            act_q    <= act_d;
            deb_q    <= deb_d;
            size_q   <= size_d;
            clk_q    <= clk_d;
            dir_q    <= dir_d;
            pull_q   <= pull_d;
            lvl_q    <= lvl_d;
            stat_q   <= stat_d;
            err_q    <= err_q | err_set;
            fifo_clr <= cfg_we;
        end
    end

    assign irq_n = (stat_q == 8'd0);

    assert_err_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ((err_q & $past(err_q)) == $past(err_q)));

    assert_err_flags_status_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (err_q != $past(err_q)) |-> stat_q[STAT_ERROR]);

    assert_noinit_kept_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_fire && cmd == OP_STAT_RD && stat_q[STAT_NOINIT]) |=> stat_q[STAT_NOINIT]);

    assert_fifo_clr_pulse_R12: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_clr |=> !fifo_clr);

    assert_cfg_releases_irq_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (param_fire && cmd == OP_CFG_WR) |=> irq_n);

endmodule

// File: rtl/kbd_rd_mux.sv
module kbd_rd_mux
    import kbd_cmd_pkg::*;
#(
    parameter int IDX_W = 4
) (
    input  logic [7:0]        cmd,
    input  logic [IDX_W-1:0]  idx,
    input  logic [7:0]        stat,
    input  logic [7:0]        err,
    input  logic [3:0]        cfg_lo,
    input  logic [7:0]        size,
    input  logic [5:0]        clk_hi,
    input  logic [WORD_W-1:0] dir,
    input  logic [WORD_W-1:0] lvl,
    output logic [7:0]        rd_byte,
    output logic              known
);

    logic [WORD_W-1:0] val;
    logic              by_index;

    always_comb begin
        known    = 1'b1;
        by_index = 1'b1;
        val      = '0;
        case (cmd)
            OP_ID_RD:   val = CHIP_ID;
            OP_STAT_RD: val = {8'h00, stat};
            OP_DIR_RD:  val = dir;
            OP_LVL_RD:  val = lvl;
            OP_ERR_RD:  begin by_index = 1'b0; val = {8'h00, err}; end
            OP_SIZE_RD: begin by_index = 1'b0; val = {8'h00, size}; end
            OP_CFG_RD:  begin by_index = 1'b0; val = {12'h000, cfg_lo}; end
            OP_CLK_RD:  begin by_index = 1'b0; val = {8'h00, clk_hi, 2'b10}; end
            default:    known = 1'b0;
        endcase

        if (!known)               rd_byte = 8'h00;
        else if (!by_index)       rd_byte = val[7:0];
        else if (idx == '0)       rd_byte = val[7:0];
        else if (idx == 'd1)      rd_byte = val[15:8];
        else                      rd_byte = 8'h00;
    end

endmodule

// File: rtl/kbd_cmd_ctrl.sv
module kbd_cmd_ctrl
    import kbd_cmd_pkg::*;
#(
    parameter int IDX_W = 4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start_wr,
    input  logic        start_rd,
    input  logic        wr_valid,
    input  logic [7:0]  wr_data,
    input  logic        rd_req,
    output logic [7:0]  rd_data,
    output logic        rd_valid,
    output logic        irq_n,
    output logic        fifo_clr,
    output logic [7:0]  cfg_o,
    output logic [7:0]  act_time_o,
    output logic [7:0]  debounce_o,
    output logic [7:0]  key_size_o,
    output logic [7:0]  clock_o,
    output logic [15:0] gpio_dir_o,
    output logic [15:0] gpio_pull_o,
    output logic [15:0] gpio_level_o
);

    logic [7:0]       cmd_q;
    logic [IDX_W-1:0] idx_q;
    logic             param_fire, rd_fire, cmd_done, rd_known;
    logic [7:0]       stat_q, err_q, rd_byte;

    kbd_txn_fsm #(.IDX_W(IDX_W)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_wr   (start_wr),
        .start_rd   (start_rd),
        .wr_valid   (wr_valid),
        .wr_data    (wr_data),
        .rd_req     (rd_req),
        .cmd_done   (cmd_done),
        .cmd_q      (cmd_q),
        .idx_q      (idx_q),
        .param_fire (param_fire),
        .rd_fire    (rd_fire)
    );

    kbd_reg_file #(.IDX_W(IDX_W)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .param_fire (param_fire),
        .cmd        (cmd_q),
        .idx        (idx_q),
        .wdata      (wr_data),
        .rd_fire    (rd_fire),
        .rd_known   (rd_known),
        .cmd_done   (cmd_done),
        .cfg_q      (cfg_o),
        .act_q      (act_time_o),
        .deb_q      (debounce_o),
        .size_q     (key_size_o),
        .clk_q      (clock_o),
        .dir_q      (gpio_dir_o),
        .pull_q     (gpio_pull_o),
        .lvl_q      (gpio_level_o),
        .stat_q     (stat_q),
        .err_q      (err_q),
        .fifo_clr   (fifo_clr),
        .irq_n      (irq_n)
    );

    kbd_rd_mux #(.IDX_W(IDX_W)) u_rd (
        .cmd     (cmd_q),
        .idx     (idx_q),
        .stat    (stat_q),
        .err     (err_q),
        .cfg_lo  (cfg_o[3:0]),
        .size    (key_size_o),
        .clk_hi  (clock_o[7:2]),
        .dir     (gpio_dir_o),
        .lvl     (gpio_level_o),
        .rd_byte (rd_byte),
        .known   (rd_known)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_valid <= 1'b0;
            rd_data  <= 8'h00;
        end else begin
            rd_valid <= rd_fire;
            if (rd_fire) rd_data <= rd_byte;
        end
    end

    assert_unknown_read_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_fire && !rd_known) |=> (rd_data == 8'h00));

endmodule

// File: tb/kbd_cmd_ctrl_tb.sv
`timescale 1ns/1ps
module kbd_cmd_ctrl_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_wr = 1'b0, start_rd = 1'b0, wr_valid = 1'b0, rd_req = 1'b0;
    logic [7:0]  wr_data = 8'h00;
    logic [7:0]  rd_data;
    logic        rd_valid, irq_n, fifo_clr;
    logic [7:0]  cfg_o, act_time_o, debounce_o, key_size_o, clock_o;
    logic [15:0] gpio_dir_o, gpio_pull_o, gpio_level_o;

    int checks = 0;
    int errors = 0;
    logic [7:0] exp_err = 8'h00;

    always #4 clk = ~clk;

    kbd_cmd_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .start_wr(start_wr), .start_rd(start_rd),
        .wr_valid(wr_valid), .wr_data(wr_data), .rd_req(rd_req),
        .rd_data(rd_data), .rd_valid(rd_valid), .irq_n(irq_n), .fifo_clr(fifo_clr),
        .cfg_o(cfg_o), .act_time_o(act_time_o), .debounce_o(debounce_o),
        .key_size_o(key_size_o), .clock_o(clock_o), .gpio_dir_o(gpio_dir_o),
        .gpio_pull_o(gpio_pull_o), .gpio_level_o(gpio_level_o)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic begin_wr();
        start_wr = 1'b1; @(negedge clk); start_wr = 1'b0;
    endtask

    task automatic begin_rd();
        start_rd = 1'b1; @(negedge clk); start_rd = 1'b0;
    endtask

    task automatic send(input logic [7:0] b);
        wr_valid = 1'b1; wr_data = b; @(negedge clk); wr_valid = 1'b0;
    endtask

    task automatic get(output logic [7:0] b);
        rd_req = 1'b1; @(negedge clk); rd_req = 1'b0;
        chk("R1 rd_valid", rd_valid, 1);
        b = rd_data;
    endtask

    task automatic read_cmd(input logic [7:0] op, output logic [7:0] b);
        begin_wr(); send(op); begin_rd(); get(b);
    endtask

    task automatic wr1(input logic [7:0] op, input logic [7:0] v);
        begin_wr(); send(op); send(v);
    endtask

    // write one parameter, then read status to see whether an error was raised
    task automatic wr_expect(input string req, input logic [7:0] op,
                             input logic [7:0] v, input logic bad);
        logic [7:0] s;
        wr1(op, v);
        read_cmd(8'h82, s);
        chk(req, s, bad ? 8'h08 : 8'h00);
        if (bad) exp_err[0] = 1'b1;
    endtask

    task automatic t_reset();
        logic [7:0] b;
        chk("R2 cfg", cfg_o, 8'h80);
        chk("R2 act", act_time_o, 8'd125);
        chk("R2 deb", debounce_o, 8'd3);
        chk("R2 size", key_size_o, 8'h33);
        chk("R2 clock", clock_o, 8'h08);
        chk("R3 irq at reset", irq_n, 0);
        read_cmd(8'h82, b);
        chk("R6 status first", b, 8'h10);
        get(b);
        chk("R6 status byte1", b, 8'h00);
        read_cmd(8'h82, b);
        chk("R6 noinit kept", b, 8'h10);
        read_cmd(8'h8C, b);
        chk("R2 error", b, 8'h00);
    endtask

    task automatic t_config();
        logic [7:0] b;
        begin_wr(); send(8'h81);
        chk("R12 no early clr", fifo_clr, 0);
        send(8'hA5);
        chk("R12 clr pulse", fifo_clr, 1);
        @(negedge clk);
        chk("R12 clr one cycle", fifo_clr, 0);
        chk("R12 cfg stored", cfg_o, 8'hA5);
        chk("R3 irq released", irq_n, 1);
        read_cmd(8'h92, b);
        chk("R8 cfg low nibble", b, 8'h05);
    endtask

    task automatic t_clock();
        logic [7:0] b;
        wr1(8'h93, 8'h0F);
        chk("R8 clock stored", clock_o, 8'h0F);
        chk("R8 clock 11 ok", irq_n, 1);
        read_cmd(8'h94, b);
        chk("R8 clock read", b, 8'h0E);
        wr1(8'h93, 8'h01);
        chk("R3 irq on error", irq_n, 0);
        exp_err[0] = 1'b1;
        read_cmd(8'h82, b);
        chk("R4 status bit3", b, 8'h08);
        chk("R6 status cleared", irq_n, 1);
        wr_expect("R8 clock 10 bad", 8'h93, 8'h02, 1);
        read_cmd(8'h8C, b);
        chk("R4 error bad param", b, exp_err);
        get(b);
        chk("R4 error not cleared", b, exp_err);
    endtask

    task automatic t_limits();
        wr_expect("R7 size 0x48", 8'h90, 8'h48, 0);
        wr_expect("R7 size cols 12", 8'h90, 8'hC3, 1);
        wr_expect("R7 size rows 13", 8'h90, 8'h3D, 1);
        wr_expect("R7 size rows 2", 8'h90, 8'h32, 1);
        wr_expect("R7 size 0x8C", 8'h90, 8'h8C, 0);
        wr_expect("R7 size 0x38", 8'h90, 8'h38, 0);
        chk("R7 size stored", key_size_o, 8'h38);
        wr_expect("R7 debounce 0", 8'h8F, 8'h00, 1);
        chk("R7 debounce stored 0", debounce_o, 8'h00);
        wr_expect("R7 debounce 5", 8'h8F, 8'h05, 0);
        chk("R7 debounce", debounce_o, 8'h05);
    endtask

    task automatic t_gpio();
        logic [7:0] b;
        begin_wr(); send(8'h85); send(8'h34); send(8'h12);
        chk("R9 dir", gpio_dir_o, 16'h1234);
        begin_wr(); send(8'h86); send(8'h78); send(8'h56);
        chk("R9 level", gpio_level_o, 16'h5678);
        begin_wr(); send(8'h84); send(8'hCD); send(8'hAB);
        chk("R9 pull", gpio_pull_o, 16'hABCD);
        begin_wr(); send(8'h84); send(8'h11);
        chk("R9 low byte clears high", gpio_pull_o, 16'h0011);
        read_cmd(8'h87, b);
        chk("R9 dir lo", b, 8'h34);
        get(b); chk("R9 dir hi", b, 8'h12);
        get(b); chk("R9 dir past end", b, 8'h00);
        read_cmd(8'h88, b);
        chk("R9 level lo", b, 8'h78);
        get(b); chk("R9 level hi", b, 8'h56);
        read_cmd(8'h82, b);
        chk("R10 clean so far", b, 8'h00);
        begin_wr(); send(8'h85); send(8'hAA); send(8'hBB); send(8'hCC);
        chk("R10 extra byte ignored dir", gpio_dir_o, 16'hBBAA);
        read_cmd(8'h82, b);
        chk("R10 extra byte bad", b, 8'h08);
    endtask

    task automatic t_unknown();
        logic [7:0] b;
        begin_wr(); send(8'h8B); send(8'h40); send(8'h11);
        chk("R13 active time", act_time_o, 8'h40);
        read_cmd(8'h82, b);
        chk("R10 after single param", b, 8'h08);
        wr1(8'h99, 8'h01);
        exp_err[1] = 1'b1;
        read_cmd(8'h82, b);
        chk("R10 unknown write", b, 8'h08);
        read_cmd(8'h9A, b);
        chk("R10 unknown read zero", b, 8'h00);
        read_cmd(8'h82, b);
        chk("R10 unknown read err", b, 8'h08);
        read_cmd(8'h8C, b);
        chk("R4 error bits", b, exp_err);
    endtask

    task automatic t_id();
        logic [7:0] b;
        read_cmd(8'h80, b);
        chk("R11 id lo", b, 8'h00);
        get(b); chk("R11 id hi", b, 8'h04);
        get(b); chk("R11 id past end", b, 8'h00);
    endtask

    task automatic t_framing();
        logic [7:0] b;
        read_cmd(8'h91, b);
        chk("R1 size read", b, 8'h38);
        send(8'h92);
        get(b);
        chk("R1 byte outside write ignored", b, 8'h38);
        begin_wr(); send(8'h91);
        rd_req = 1'b1; @(negedge clk); rd_req = 1'b0;
        chk("R1 read outside read", rd_valid, 0);
        start_wr = 1'b1; wr_valid = 1'b1; wr_data = 8'h83;
        @(negedge clk); start_wr = 1'b0; wr_valid = 1'b0;
        send(8'h8B); send(8'h22);
        chk("R1 start wins", act_time_o, 8'h22);
    endtask

    task automatic t_soft();
        logic [7:0] b;
        wr_expect("R5 wrong key", 8'h83, 8'h55, 1);
        chk("R5 no reset on wrong key", act_time_o, 8'h22);
        wr1(8'h83, 8'hAA);
        chk("R5 cfg", cfg_o, 8'h80);
        chk("R5 act", act_time_o, 8'd125);
        chk("R5 deb", debounce_o, 8'd3);
        chk("R5 size", key_size_o, 8'h33);
        chk("R5 clock", clock_o, 8'h08);
        chk("R5 dir kept", gpio_dir_o, 16'hBBAA);
        chk("R3 irq after soft reset", irq_n, 0);
        read_cmd(8'h82, b);
        chk("R5 status", b, 8'h10);
        read_cmd(8'h8C, b);
        chk("R5 error kept", b, exp_err);
    endtask

    task automatic t_hard();
        logic [7:0] b;
        rst_n = 1'b0; @(negedge clk); @(negedge clk); rst_n = 1'b1; @(negedge clk);
        exp_err = 8'h00;
        read_cmd(8'h8C, b);
        chk("R4 error cleared by rst_n", b, 8'h00);
        chk("R2 dir", gpio_dir_o, 16'h0000);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_config();
        t_clock();
        t_limits();
        t_gpio();
        t_unknown();
        t_id();
        t_framing();
        t_soft();
        t_hard();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule